// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and takes the memory from power-on to a usable state. After a synchronous reset it holds clock enable low for a programmable startup interval. It then raises clock enable with one NOP and plays a fixed script of seven commands on the command pins: precharge of all banks, an extended mode register write that enables the DLL, a mode register write that resets the DLL and programs the operating parameters, a second precharge of all banks, two auto refreshes, and a final mode register write with the DLL-reset bit cleared.

Every interval between commands is a parameter in clock cycles, and NOPs fill each gap. Burst length, burst type and CAS latency come from input ports and are packed into the mode register address. A separate counter starts at the DLL-reset command. The read-permit output stays low until that counter has covered the DLL lock interval and the script has finished. A downstream scheduler waits for `init_done` before it issues any command and for `read_allowed` before the first read.

Top module: `sdram_powerup_seq`

## Requirements
- R1: With `rst` high at a rising edge, the next cycle shows `cke` low, `init_done` low and `read_allowed` low, and the whole sequence restarts from the startup wait. This holds at any point of the sequence, including after it has finished.
- R2: Counting the cycle before the first edge with `rst` low as cycle 0, cycles 0 to T_STARTUP-1 drive `cke` low with `cs_n` high (deselect).
- R3: In cycle T_STARTUP, `cke` goes high and the pins carry a NOP: {cs_n,ras_n,cas_n,we_n} = 0111.
- R4: After the NOP, exactly seven non-NOP commands follow, in this order: PRECHARGE ALL, extended MRS, MRS with DLL reset, PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, MRS. The encodings on {cs_n,ras_n,cas_n,we_n} are PRECHARGE 0010, AUTO REFRESH 0001 and MRS 0000.
- R5: Each PRECHARGE ALL drives address bit 10 high, all other address bits low, and bank address 00.
- R6: The extended MRS uses bank address 01 with every address bit zero, so A0 = 0 enables the DLL.
- R7: Both MRS commands use bank address 00. The address holds burst length code in A[2:0], burst type in A3 (1 = interleaved) and CAS latency code in A[6:4], with all other bits zero except A8. A8 is 1 on the first MRS (DLL reset) and 0 on the final one.
- R8: The first precharge comes one cycle after the NOP. Each later command comes T_RP cycles after a precharge, T_MRD after a mode register write and T_RFC after an auto refresh. Every cycle in between is a NOP with `cke` high.
- R9: `init_done` rises T_MRD cycles after the final MRS and stays high until reset.
- R10: `read_allowed` rises in the later of two cycles: T_DLL_LOCK cycles after the DLL-reset MRS, or the cycle in which `init_done` rises. It stays high until reset.
- R11: The operating parameter inputs appear only in the MRS address fields. The extended MRS, precharge, refresh and NOP cycles carry the same address whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| burst_len_code | input | 3 | Burst length code for A[2:0] |
| burst_interleave | input | 1 | Burst type for A3 |
| cas_lat_code | input | 3 | CAS latency code for A[6:4] |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |
| read_allowed | output | 1 | DLL lock interval elapsed; reads permitted |

## Verification
A wrong step index or a wrong gap counter shows at the command pins within a single cycle: a command comes out of order, a cycle early or late, or with the wrong bank or address bits. The bench records the cycle of every non-NOP command and compares it against a schedule computed from the timing parameters. A fault in the lock counter appears only at the edge of `read_allowed`. That edge comes well after `init_done` with the default lock interval, so the bench checks the exact rising cycle in every run.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_REFRESH,
    CMD_MRS,
    CMD_EMRS
  } cmd_e;

  localparam int unsigned LAST_STEP      = 6;
  localparam int unsigned DLL_RESET_STEP = 2;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    case (c)
      CMD_NOP:     return 4'b0111;
      CMD_PRE_ALL: return 4'b0010;
      CMD_REFRESH: return 4'b0001;
      CMD_MRS,
      CMD_EMRS:    return 4'b0000;
      default:     return 4'b1111;
    endcase
  endfunction

  function automatic cmd_e step_cmd(logic [2:0] step);
    case (step)
      3'd0, 3'd3: return CMD_PRE_ALL;
      3'd1:       return CMD_EMRS;
      3'd4, 3'd5: return CMD_REFRESH;
      default:    return CMD_MRS;
    endcase
  endfunction

endpackage

// File: rtl/pwrup_cmd_drive.sv
module pwrup_cmd_drive #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  pwrup_pkg::cmd_e    cmd,
  input  logic               dll_reset_bit,
  input  logic [2:0]         burst_len_code,
  input  logic               burst_interleave,
  input  logic [2:0]         cas_lat_code,
  output logic               cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [BA_W-1:0]    ba,
  output logic [ADDR_W-1:0]  addr
);
  import pwrup_pkg::*;

  localparam int DLL_RST_BIT = 8;
  localparam int ALL_BANK_BIT = 10;

  function automatic logic [ADDR_W-1:0] mode_addr(logic [2:0] bl, logic bt,
                                                  logic [2:0] cl, logic dllr);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[2:0] = bl;
    a[3] = bt;
    a[6:4] = cl;
    a[DLL_RST_BIT] = dllr;
    return a;
  endfunction

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = cmd_pins(cmd);
    ba   = '0;
    addr = '0;
    case (cmd)
      CMD_PRE_ALL: addr[ALL_BANK_BIT] = 1'b1;
      CMD_MRS:     addr = mode_addr(burst_len_code, burst_interleave,
                                    cas_lat_code, dll_reset_bit);
      CMD_EMRS:    ba = BA_W'(1);   // A0 = 0 keeps the DLL enabled
      default: ;
    endcase
  end

endmodule

// File: rtl/pwrup_dll_lock.sv
module pwrup_dll_lock #(
  parameter int T_LOCK = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic locked
);
  localparam int W = $clog2(T_LOCK + 1);

  logic [W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst)
      elapsed <= '0;
    else if (start)
      elapsed <= W'(1);
    else if (elapsed != '0 && elapsed != W'(T_LOCK))
      elapsed <= elapsed + 1'b1;
  end

  assign locked = (elapsed == W'(T_LOCK));

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int T_STARTUP  = 20000,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 10,
  parameter int T_DLL_LOCK = 200,
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        burst_len_code,
  input  logic              burst_interleave,
  input  logic [2:0]        cas_lat_code,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              read_allowed
);
  import pwrup_pkg::*;

  localparam int MAX_A = (T_STARTUP > T_RFC) ? T_STARTUP : T_RFC;
  localparam int MAX_B = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int MAX_T = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int CNT_W = $clog2(MAX_T + 1);

  typedef enum logic [2:0] {ST_START, ST_WAKE, ST_ISSUE, ST_GAP, ST_READY} st_e;

  st_e              state;
  logic [2:0]       step;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] gap_len(logic [2:0] s);
    case (s)
      3'd0, 3'd3: return CNT_W'(T_RP);
      3'd4, 3'd5: return CNT_W'(T_RFC);
      default:    return CNT_W'(T_MRD);
    endcase
  endfunction

  // named events for the checker
  logic start_end, gap_end, cmd_issue, dll_reset_issue, lock_done;
  cmd_e cur_cmd;

  assign start_end       = (cnt == CNT_W'(T_STARTUP - 1));
  assign gap_end         = (cnt >= gap_len(step) - 1'b1);
  assign cmd_issue       = (state == ST_ISSUE);
  assign dll_reset_issue = cmd_issue && (step == 3'(DLL_RESET_STEP));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_START;
      step  <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        ST_START: if (start_end) state <= ST_WAKE;
                  else           cnt   <= cnt + 1'b1;
        ST_WAKE: begin
          state <= ST_ISSUE;
          step  <= '0;
        end
        ST_ISSUE: begin
          state <= ST_GAP;
          cnt   <= CNT_W'(1);
        end
        ST_GAP: begin
          if (gap_end) begin
            if (step == 3'(LAST_STEP)) state <= ST_READY;
            else begin
              state <= ST_ISSUE;
              step  <= step + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_READY;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: cur_cmd = CMD_DESEL;
      ST_ISSUE: cur_cmd = step_cmd(step);
      default:  cur_cmd = CMD_NOP;
    endcase
  end

  assign cke       = (state != ST_START);
  assign init_done = (state == ST_READY);

  pwrup_cmd_drive #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_drive (
    .cmd              (cur_cmd),
    .dll_reset_bit    (step == 3'(DLL_RESET_STEP)),
    .burst_len_code   (burst_len_code),
    .burst_interleave (burst_interleave),
    .cas_lat_code     (cas_lat_code),
    .cs_n             (cs_n),
    .ras_n            (ras_n),
    .cas_n            (cas_n),
    .we_n             (we_n),
    .ba               (ba),
    .addr             (addr)
  );

  pwrup_dll_lock #(.T_LOCK(T_DLL_LOCK)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .start  (dll_reset_issue),
    .locked (lock_done)
  );

  assign read_allowed = init_done && lock_done;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              read_allowed,
  input logic              cmd_issue,
  input logic              dll_reset_issue
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cke && !init_done && !read_allowed));

  assert_deselect_in_wait_R2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cs_n);

  assert_dll_reset_mrs_R4: assert property (@(posedge clk) disable iff (rst)
    dll_reset_issue |-> (!cs_n && !ras_n && !cas_n && !we_n && ba == '0 && addr[8]));

  assert_precharge_all_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);

  assert_emrs_dll_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && !cas_n && !we_n && ba == BA_W'(1)) |-> (addr == '0));

  assert_gap_nop_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_issue |=> (cke && !cs_n && ras_n && cas_n && we_n));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_read_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    read_allowed |-> init_done);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cke             (cke),
  .cs_n            (cs_n),
  .ras_n           (ras_n),
  .cas_n           (cas_n),
  .we_n            (we_n),
  .ba              (ba),
  .addr            (addr),
  .init_done       (init_done),
  .read_allowed    (read_allowed),
  .cmd_issue       (cmd_issue),
  .dll_reset_issue (dll_reset_issue)
);

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;
  localparam int CLK_P  = 10;
  localparam int T_ST   = 40;
  localparam int T_RP   = 3;
  localparam int T_MRD  = 2;
  localparam int T_RFC  = 6;
  localparam int T_DLL  = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bl = 3'd0;
  logic        bt = 1'b0;
  logic [2:0]  cl = 3'd0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done, read_allowed;
  logic [1:0]  ba;
  logic [12:0] addr;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_powerup_seq #(
    .T_STARTUP(T_ST), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .T_DLL_LOCK(T_DLL), .ADDR_W(13), .BA_W(2)
  ) uut (
    .clk(clk), .rst(rst), .burst_len_code(bl), .burst_interleave(bt),
    .cas_lat_code(cl), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done),
    .read_allowed(read_allowed)
  );

  task automatic chk(string req, int s, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, s, act, exp);
    end
  endtask

  function automatic logic [12:0] mode_word(logic [2:0] b, logic t, logic [2:0] c, logic d);
    logic [12:0] w;
    w = 13'd0;
    w[2:0] = b;  w[3] = t;  w[6:4] = c;  w[8] = d;
    return w;
  endfunction

  // abort_at = 0 runs to the end; otherwise stops after that cycle
  task automatic run_seq(logic [2:0] b, logic t, logic [2:0] c, int abort_at);
    int          et[7];
    logic [3:0]  ep[7];
    logic [1:0]  eb[7];
    logic [12:0] ea[7];
    int ready_t, ra_t, last, ncmd;
    logic [3:0] pins;

    et[0] = T_ST + 1;
    et[1] = et[0] + T_RP;
    et[2] = et[1] + T_MRD;
    et[3] = et[2] + T_MRD;
    et[4] = et[3] + T_RP;
    et[5] = et[4] + T_RFC;
    et[6] = et[5] + T_RFC;
    ready_t = et[6] + T_MRD;
    ra_t = (et[2] + T_DLL > ready_t) ? et[2] + T_DLL : ready_t;
    ep = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
    eb = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
    ea[0] = 13'h400;  ea[1] = 13'd0;  ea[2] = mode_word(b, t, c, 1'b1);
    ea[3] = 13'h400;  ea[4] = 13'd0;  ea[5] = 13'd0;
    ea[6] = mode_word(b, t, c, 1'b0);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 cke", 0, cke, 0);
    chk("R1 init_done", 0, init_done, 0);
    chk("R1 read_allowed", 0, read_allowed, 0);
    bl = b; bt = t; cl = c;
    rst = 1'b0;
    ncmd = 0;
    last = ra_t + 8;
    for (int s = 1; s <= last; s++) begin
      @(negedge clk);
      pins = {cs_n, ras_n, cas_n, we_n};
      chk("R2/R3 cke", s, cke, (s >= T_ST));
      if (s < T_ST) chk("R2 deselect", s, cs_n, 1);
      else if (s == T_ST) chk("R3 wake nop", s, pins, 4'b0111);
      else if (pins != 4'b0111) begin
        if (ncmd < 7) begin
          chk("R8 command cycle", s, s, et[ncmd]);
          chk("R4 command code", s, pins, ep[ncmd]);
          chk("R5/R6/R7 bank", s, ba, eb[ncmd]);
          chk("R5/R6/R7/R11 address", s, addr, ea[ncmd]);
        end else chk("R4 extra command", s, pins, 4'b0111);
        ncmd++;
      end else begin
        chk("R11 idle address", s, {ba, addr}, 0);
      end
      chk("R9 init_done", s, init_done, (s >= ready_t));
      chk("R10 read_allowed", s, read_allowed, (s >= ra_t));
      if (abort_at != 0 && s == abort_at) return;
    end
    chk("R4 command count", last, ncmd, 7);
  endtask

  initial begin
    #(CLK_P * 50000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd2718);
    // directed: typical settings, then corner codes
    run_seq(3'b010, 1'b0, 3'b010, 0);
    run_seq(3'b111, 1'b1, 3'b111, 0);
    run_seq(3'b000, 1'b0, 3'b000, 0);
    // R1: reset during startup wait and in the middle of the script
    run_seq(3'b011, 1'b1, 3'b110, 10);
    run_seq(3'b001, 1'b0, 3'b011, T_ST + 8);
    run_seq(3'b001, 1'b1, 3'b101, T_ST + 1 + T_RP + 2 * T_MRD + T_RP + 3);
    // random operating parameters
    for (int i = 0; i < 6; i++)
      run_seq(3'($urandom), 1'($urandom), 3'($urandom), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule